// File: doc/BRIEF.md
# Output Stage Protection and Mode Controller

This block sits beside a line-driver output stage and decides, each clock cycle, whether the stage may drive, whether its bias is on and whether it runs in a reduced-power state. It combines an over-current detect flag, an 8-bit junction-temperature code (degrees Celsius), an 8-bit supply code (50 mV per step), an active-low hold/disable input, a clearing-mode select, a low-power request and two test inputs. From these it produces a latched fault flag and three enables.

A fault, either over-current or thermal, sets a latch that disables the output. The latch clears in one of two ways. In manual mode, a hold pulse of at least 100 ns is required once the cause has gone. In automatic mode, a free-running 1 µs retry timer clears it, and a release of the hold input also clears it at once. Temperature and supply are compared against two thresholds each, with hysteresis between them. Pulse width and retry period are derived in clock cycles from a clock-frequency parameter.

Top module: `drv_guard_ctrl`

## Requirements
- R1: While the block reset `rst_n` is low, and with `bias_force` low, all four outputs are low.
- R2: A temperature code above TEMP_TRIP (default 160) sets `fault_flag` two cycles later, and `out_en` goes low. A code equal to TEMP_TRIP sets nothing.
- R3: The thermal cause persists until the temperature code falls below TEMP_REARM (default 120). While the cause persists, including at a code of exactly 120, no clearing mechanism can reset the fault.
- R4: Supply lockout: `out_en` stays low until the supply code rises above VSUP_ON (default 84, 4.2 V). It then stays enabled until the code falls below VSUP_OFF (default 80, 4.0 V).
- R5: With `auto_mode` low, a latched fault remains set until `hold_n` has been low for at least PULSE_CYC consecutive cycles (default 25, which is 100 ns at 250 MHz) and no cause is present. It clears on the clock edge at which `hold_n` is first seen high again.
- R6: With `auto_mode` low, a hold pulse shorter than PULSE_CYC cycles does not clear the fault.
- R7: With `auto_mode` high, a latched fault with no cause present clears at the next retry tick, within RETRY_CYC (default 250, 1 µs) cycles, with no pulse needed. A release of `hold_n` also clears it on the edge after the release.
- R8: Over-current counts as a cause only while `out_en` is high. With `auto_mode` high and the over-current persistent, `fault_flag` falls once every RETRY_CYC cycles and stays low for exactly one cycle each time.
- R9: While `hold_n` is low, `out_en`, `bias_en` and `lp_en` are low, even with `bias_force` high.
- R10: With `hold_n` high, `bias_force` high keeps `bias_en` high regardless of any fault or supply lockout.
- R11: `therm_inject` high acts as a thermal cause. It sets the fault and holds it across retry ticks.
- R12: `lp_en` equals `out_en` AND `lowpwr_req`, and `lowpwr_req` has no effect on `out_en`.
- R13: While `fault_flag` is high, `out_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| ovc_det | input | 1 | Over-current detect from the output stage |
| temp_code | input | 8 | Junction temperature, unsigned degrees Celsius |
| vsup_code | input | 8 | Supply voltage in 50 mV steps |
| hold_n | input | 1 | Active-low disable; its low pulses clear the latch in manual mode |
| auto_mode | input | 1 | 1 selects automatic retry clearing, 0 selects pulse clearing |
| lowpwr_req | input | 1 | Requests the reduced-power state |
| bias_force | input | 1 | Test: keep bias on regardless of faults |
| therm_inject | input | 1 | Test: behave as if over temperature |
| fault_flag | output | 1 | Latched fault indication |
| out_en | output | 1 | Output stage may drive the line |
| lp_en | output | 1 | Output stage runs in reduced power |
| bias_en | output | 1 | Output stage bias on |

## Verification
Most internal state here shows up at the ports within one or two cycles. A stuck or mis-set hysteresis state flips `out_en` or `fault_flag` two cycles after a threshold crossing. A wrong fault latch is visible on the very next edge. A miscounted pulse qualifier shows only at the release edge of a hold pulse that is exactly at, or one cycle below, the minimum width. A wrong retry period shows only as a fault-to-fault spacing other than RETRY_CYC in the persistent over-current cycle, so that spacing is measured directly.

// File: rtl/drv_guard_pkg.sv
`timescale 1ns/1ps
package drv_guard_pkg;

  typedef enum logic {
    CLR_BY_PULSE = 1'b0,
    CLR_BY_RETRY = 1'b1
  } clr_mode_e;

  // cycles covering a time span, rounded up
  function automatic int ns_to_cyc(input longint clk_hz, input longint span_ns);
    longint prod;
    prod = clk_hz * span_ns;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/drv_guard_rst_sync.sv
`timescale 1ns/1ps
module drv_guard_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ln
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_ln = sync_q[STAGES-1];

endmodule

// File: rtl/drv_guard_hyst.sv
`timescale 1ns/1ps
module drv_guard_hyst #(
  parameter int CODE_W  = 8,
  parameter int SET_LVL = 160,
  parameter int CLR_LVL = 120
) (
  input  logic              clk,
  input  logic              rst_ln,
  input  logic [CODE_W-1:0] code,
  output logic              state_q
);

  localparam logic [CODE_W-1:0] SET_C = CODE_W'(SET_LVL);
  localparam logic [CODE_W-1:0] CLR_C = CODE_W'(CLR_LVL);

  logic set_hit;
  logic clr_hit;
  logic state_d;
  logic state_en;

  always_comb begin
    set_hit  = (code > SET_C);
    clr_hit  = (code < CLR_C);
    state_d  = state_q;
    if (set_hit) begin
      state_d = 1'b1;
    end else if (clr_hit) begin
      state_d = 1'b0;
    end
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      state_q <= 1'b0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/drv_guard_pulse_qual.sv
`timescale 1ns/1ps
module drv_guard_pulse_qual #(
  parameter int MIN_CYC = 25
) (
  input  logic clk,
  input  logic rst_ln,
  input  logic hold_n,
  output logic qual_rel,
  output logic any_rel
);

  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_CYC);

  logic [CW-1:0] low_cnt_q;
  logic [CW-1:0] low_cnt_d;
  logic          low_cnt_en;

  always_comb begin
    if (hold_n) begin
      low_cnt_d  = '0;
      low_cnt_en = (low_cnt_q != '0);
    end else begin
      low_cnt_d  = low_cnt_q + 1'b1;
      low_cnt_en = (low_cnt_q != SAT);
    end
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      low_cnt_q <= '0;
    end else if (low_cnt_en) begin
      low_cnt_q <= low_cnt_d;
    end
  end

  assign qual_rel = hold_n && (low_cnt_q == SAT);
  assign any_rel  = hold_n && (low_cnt_q != '0);

endmodule

// File: rtl/drv_guard_retry.sv
`timescale 1ns/1ps
module drv_guard_retry #(
  parameter int PERIOD = 250
) (
  input  logic clk,
  input  logic rst_ln,
  output logic tick
);

  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/drv_guard_latch.sv
`timescale 1ns/1ps
module drv_guard_latch
  import drv_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_ln,
  input  logic therm_hot,
  input  logic therm_inject,
  input  logic ovc_det,
  input  logic drive_on,
  input  logic auto_mode,
  input  logic qual_rel,
  input  logic any_rel,
  input  logic tick,
  output logic flt_q
);

  clr_mode_e mode;
  logic      cause;
  logic      clr_req;
  logic      flt_d;
  logic      flt_en;

  always_comb begin
    mode  = clr_mode_e'(auto_mode);
    // over-current is only observable while the stage drives
    cause = therm_hot | therm_inject | (ovc_det & drive_on);
    case (mode)
      CLR_BY_RETRY: clr_req = tick | any_rel;
      default:      clr_req = qual_rel;
    endcase
    flt_d  = cause | (flt_q & ~clr_req);
    flt_en = (flt_d != flt_q);
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      flt_q <= 1'b0;
    end else if (flt_en) begin
      flt_q <= flt_d;
    end
  end

endmodule

// File: rtl/drv_guard_ctrl.sv
`timescale 1ns/1ps
module drv_guard_ctrl
  import drv_guard_pkg::*;
#(
  parameter longint CLK_HZ       = 250_000_000,
  parameter int     CLR_PULSE_NS = 100,
  parameter int     RETRY_NS     = 1000,
  parameter int     CODE_W       = 8,
  parameter int     TEMP_TRIP    = 160,
  parameter int     TEMP_REARM   = 120,
  parameter int     VSUP_ON      = 84,
  parameter int     VSUP_OFF     = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovc_det,
  input  logic [CODE_W-1:0] temp_code,
  input  logic [CODE_W-1:0] vsup_code,
  input  logic              hold_n,
  input  logic              auto_mode,
  input  logic              lowpwr_req,
  input  logic              bias_force,
  input  logic              therm_inject,
  output logic              fault_flag,
  output logic              out_en,
  output logic              lp_en,
  output logic              bias_en
);

  localparam int PULSE_CYC = ns_to_cyc(CLK_HZ, longint'(CLR_PULSE_NS));
  localparam int RETRY_CYC = ns_to_cyc(CLK_HZ, longint'(RETRY_NS));

  logic rst_ln;
  logic therm_hot;
  logic supply_ok;
  logic qual_rel;
  logic any_rel;
  logic tick;
  logic flt_q;
  logic drive_on;

  drv_guard_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ln (rst_ln)
  );

  drv_guard_hyst #(
    .CODE_W  (CODE_W),
    .SET_LVL (TEMP_TRIP),
    .CLR_LVL (TEMP_REARM)
  ) u_therm (
    .clk     (clk),
    .rst_ln  (rst_ln),
    .code    (temp_code),
    .state_q (therm_hot)
  );

  drv_guard_hyst #(
    .CODE_W  (CODE_W),
    .SET_LVL (VSUP_ON),
    .CLR_LVL (VSUP_OFF)
  ) u_supply (
    .clk     (clk),
    .rst_ln  (rst_ln),
    .code    (vsup_code),
    .state_q (supply_ok)
  );

  drv_guard_pulse_qual #(.MIN_CYC(PULSE_CYC)) u_qual (
    .clk      (clk),
    .rst_ln   (rst_ln),
    .hold_n   (hold_n),
    .qual_rel (qual_rel),
    .any_rel  (any_rel)
  );

  drv_guard_retry #(.PERIOD(RETRY_CYC)) u_retry (
    .clk    (clk),
    .rst_ln (rst_ln),
    .tick   (tick)
  );

  drv_guard_latch u_latch (
    .clk          (clk),
    .rst_ln       (rst_ln),
    .therm_hot    (therm_hot),
    .therm_inject (therm_inject),
    .ovc_det      (ovc_det),
    .drive_on     (drive_on),
    .auto_mode    (auto_mode),
    .qual_rel     (qual_rel),
    .any_rel      (any_rel),
    .tick         (tick),
    .flt_q        (flt_q)
  );

  always_comb begin
    drive_on   = hold_n & supply_ok & ~flt_q;
    out_en     = drive_on;
    lp_en      = drive_on & lowpwr_req;
    bias_en    = hold_n & (bias_force | (supply_ok & ~flt_q));
    fault_flag = flt_q;
  end

endmodule

// File: rtl/drv_guard_chk.sv
`timescale 1ns/1ps
module drv_guard_chk #(
  parameter int CODE_W    = 8,
  parameter int TEMP_TRIP = 160,
  parameter int VSUP_OFF  = 80
) (
  input logic              clk,
  input logic              rst_ln,
  input logic              hold_n,
  input logic              auto_mode,
  input logic              lowpwr_req,
  input logic              bias_force,
  input logic [CODE_W-1:0] temp_code,
  input logic [CODE_W-1:0] vsup_code,
  input logic              fault_flag,
  input logic              out_en,
  input logic              lp_en,
  input logic              bias_en
);

  logic [1:0] live_q;
  logic       live;

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      live_q <= '0;
    end else if (live_q != 2'd3) begin
      live_q <= live_q + 2'd1;
    end
  end

  assign live = (live_q == 2'd3);

  // R13
  fault_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    fault_flag |-> !out_en);

  // R9
  hold_disables_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    !hold_n |-> (!out_en && !bias_en && !lp_en));

  // R12
  lowpwr_gating_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    lp_en |-> (out_en && lowpwr_req));

  // R10
  bias_override_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (hold_n && bias_force) |-> bias_en);

  // R2
  thermal_trip_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (live && ($past(temp_code, 2) > CODE_W'(TEMP_TRIP))) |-> fault_flag);

  // R4
  supply_lockout_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (live && ($past(vsup_code) < CODE_W'(VSUP_OFF))) |-> !out_en);

  // R5
  manual_release_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (live && $fell(fault_flag) && !$past(auto_mode)) |-> ($past(hold_n) && !$past(hold_n, 2)));

endmodule

bind drv_guard_ctrl drv_guard_chk #(
  .CODE_W    (CODE_W),
  .TEMP_TRIP (TEMP_TRIP),
  .VSUP_OFF  (VSUP_OFF)
) u_chk (
  .clk        (clk),
  .rst_ln     (rst_ln),
  .hold_n     (hold_n),
  .auto_mode  (auto_mode),
  .lowpwr_req (lowpwr_req),
  .bias_force (bias_force),
  .temp_code  (temp_code),
  .vsup_code  (vsup_code),
  .fault_flag (fault_flag),
  .out_en     (out_en),
  .lp_en      (lp_en),
  .bias_en    (bias_en)
);

// File: tb/drv_guard_ctrl_bench.sv
`timescale 1ns/1ps
module drv_guard_ctrl_bench;

  localparam int PULSE_CYC  = 25;
  localparam int RETRY_CYC  = 250;
  localparam int TEMP_TRIP  = 160;
  localparam int TEMP_REARM = 120;
  localparam int VSUP_ON    = 84;
  localparam int VSUP_OFF   = 80;

  logic       clk;
  logic       rst_n;
  logic       ovc_drv;
  logic       short_mode;
  logic       ovc_det;
  logic [7:0] temp_code;
  logic [7:0] vsup_code;
  logic       hold_n;
  logic       auto_mode;
  logic       lowpwr_req;
  logic       bias_force;
  logic       therm_inject;
  logic       fault_flag;
  logic       out_en;
  logic       lp_en;
  logic       bias_en;

  int n_cmp;
  int n_bad;
  bit done;

  assign ovc_det = ovc_drv | (short_mode & out_en);

  drv_guard_ctrl u_drv_guard_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovc_det      (ovc_det),
    .temp_code    (temp_code),
    .vsup_code    (vsup_code),
    .hold_n       (hold_n),
    .auto_mode    (auto_mode),
    .lowpwr_req   (lowpwr_req),
    .bias_force   (bias_force),
    .therm_inject (therm_inject),
    .fault_flag   (fault_flag),
    .out_en       (out_en),
    .lp_en        (lp_en),
    .bias_en      (bias_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model state (manual clearing only)
  logic m_therm, m_uv, m_flt;
  int   m_low;

  function automatic logic f_out(input logic h, input logic uv, input logic flt);
    return h & uv & ~flt;
  endfunction

  function automatic logic f_bias(input logic h, input logic frc, input logic uv, input logic flt);
    return h & (frc | (uv & ~flt));
  endfunction

  function automatic logic f_hyst(input logic st, input int code, input int hi, input int lo);
    if (code > hi) return 1'b1;
    if (code < lo) return 1'b0;
    return st;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hold_pulse(input int width);
    hold_n = 1'b0;
    step(width);
    hold_n = 1'b1;
    step(1);
  endtask

  task automatic wait_flag(input logic val, input int limit, output int took);
    took = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (fault_flag === val) begin
        took = i;
        break;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #600000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    int took;
    int gap;
    int lows;
    logic prev;
    void'($urandom(32'h5EED_2041));
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; ovc_drv = 1'b0; short_mode = 1'b0;
    temp_code = 8'd25; vsup_code = 8'd0; hold_n = 1'b1;
    auto_mode = 1'b0; lowpwr_req = 1'b0; bias_force = 1'b0; therm_inject = 1'b0;
    step(5);
    // R1 reset state
    chk("R1", "fault_flag", fault_flag, 1'b0);
    chk("R1", "out_en", out_en, 1'b0);
    chk("R1", "bias_en", bias_en, 1'b0);
    chk("R1", "lp_en", lp_en, 1'b0);
    rst_n = 1'b1;
    step(4);

    // R4 supply lockout thresholds
    chk("R4", "out_en low supply", out_en, 1'b0);
    vsup_code = 8'(VSUP_ON); step(3);
    chk("R4", "out_en at on level", out_en, 1'b0);
    vsup_code = 8'(VSUP_ON + 1); step(2);
    chk("R4", "out_en above on level", out_en, 1'b1);
    vsup_code = 8'(VSUP_OFF + 2); step(3);
    chk("R4", "out_en inside band", out_en, 1'b1);
    vsup_code = 8'(VSUP_OFF); step(3);
    chk("R4", "out_en at off level", out_en, 1'b1);
    vsup_code = 8'(VSUP_OFF - 1); step(2);
    chk("R4", "out_en below off level", out_en, 1'b0);
    bias_force = 1'b1; step(1);
    chk("R10", "bias_en forced under lockout", bias_en, 1'b1);
    bias_force = 1'b0;
    vsup_code = 8'd90; step(2);
    chk("R4", "out_en restored", out_en, 1'b1);

    // R12 low-power
    lowpwr_req = 1'b1; step(1);
    chk("R12", "lp_en", lp_en, 1'b1);
    chk("R12", "out_en kept", out_en, 1'b1);
    lowpwr_req = 1'b0; step(1);
    chk("R12", "lp_en off", lp_en, 1'b0);

    // R2 thermal trip boundary
    temp_code = 8'(TEMP_TRIP); step(3);
    chk("R2", "flag at trip level", fault_flag, 1'b0);
    temp_code = 8'(TEMP_TRIP + 1); step(1);
    chk("R2", "flag one cycle after", fault_flag, 1'b0);
    step(1);
    chk("R2", "flag two cycles after", fault_flag, 1'b1);
    chk("R13", "out_en under fault", out_en, 1'b0);
    bias_force = 1'b1; step(1);
    chk("R10", "bias_en forced under fault", bias_en, 1'b1);
    bias_force = 1'b0; step(1);
    chk("R10", "bias_en released", bias_en, 1'b0);
    lowpwr_req = 1'b1; step(1);
    chk("R12", "lp_en under fault", lp_en, 1'b0);
    lowpwr_req = 1'b0;

    // R3 hysteresis holds the cause
    temp_code = 8'd130; step(2);
    hold_pulse(PULSE_CYC);
    chk("R3", "flag inside band after pulse", fault_flag, 1'b1);
    temp_code = 8'(TEMP_REARM); step(2);
    hold_pulse(PULSE_CYC);
    chk("R3", "flag at rearm level after pulse", fault_flag, 1'b1);
    temp_code = 8'(TEMP_REARM - 1); step(2);
    hold_pulse(PULSE_CYC - 1);
    chk("R6", "flag after short pulse", fault_flag, 1'b1);
    hold_pulse(PULSE_CYC);
    chk("R5", "flag after full pulse", fault_flag, 1'b0);
    chk("R5", "out_en after full pulse", out_en, 1'b1);

    // R9 disabled mode
    hold_n = 1'b0; bias_force = 1'b1; lowpwr_req = 1'b1; step(1);
    chk("R9", "out_en while held", out_en, 1'b0);
    chk("R9", "bias_en while held", bias_en, 1'b0);
    chk("R9", "lp_en while held", lp_en, 1'b0);
    hold_n = 1'b1; bias_force = 1'b0; lowpwr_req = 1'b0; step(2);

    // R11 injected thermal fault, manual clear
    therm_inject = 1'b1; step(1);
    chk("R11", "flag from inject", fault_flag, 1'b1);
    therm_inject = 1'b0; step(300);
    chk("R5", "flag held in manual", fault_flag, 1'b1);
    hold_pulse(PULSE_CYC);
    chk("R5", "flag cleared after inject", fault_flag, 1'b0);

    // R7 automatic retry after a one-cycle over-current
    auto_mode = 1'b1; step(1);
    ovc_drv = 1'b1; step(1);
    ovc_drv = 1'b0;
    chk("R7", "flag set by over-current", fault_flag, 1'b1);
    wait_flag(1'b0, RETRY_CYC + 5, took);
    chk("R7", "auto clear found", took > 0 && took <= RETRY_CYC, 1'b1);

    // R11 inject held across ticks in auto mode
    therm_inject = 1'b1; step(3 * RETRY_CYC);
    chk("R11", "flag held across ticks", fault_flag, 1'b1);
    therm_inject = 1'b0;
    wait_flag(1'b0, RETRY_CYC + 5, took);
    chk("R7", "auto clear after inject", took > 0 && took <= RETRY_CYC, 1'b1);

    // R7 release of hold in auto mode clears without waiting
    auto_mode = 1'b0; therm_inject = 1'b1; step(1);
    therm_inject = 1'b0; step(5);
    chk("R5", "flag latched before switch", fault_flag, 1'b1);
    auto_mode = 1'b1; hold_n = 1'b0; step(1);
    hold_n = 1'b1; step(1);
    chk("R7", "flag after release in auto", fault_flag, 1'b0);

    // R8 persistent over-current cycles with the retry period
    short_mode = 1'b1;
    wait_flag(1'b1, 5, took);
    chk("R8", "flag set by short", took > 0, 1'b1);
    wait_flag(1'b0, 2 * RETRY_CYC, took);
    chk("R8", "first retry seen", took > 0, 1'b1);
    gap = 0; lows = 0; prev = 1'b0;
    for (int i = 1; i <= 3 * RETRY_CYC; i++) begin
      @(negedge clk);
      if (fault_flag === 1'b0) lows++;
      if (prev === 1'b1 && fault_flag === 1'b0) begin
        gap = i;
        break;
      end
      prev = fault_flag;
    end
    chk_int("R8", "retry spacing", gap, RETRY_CYC);
    chk_int("R8", "low cycles per retry", lows, 1);
    short_mode = 1'b0;
    wait_flag(1'b0, RETRY_CYC + 5, took);
    chk("R8", "clear once short gone", took > 0, 1'b1);

    // random phase, manual clearing, against the bench model
    auto_mode = 1'b0; temp_code = 8'd25; vsup_code = 8'd90; hold_n = 1'b1;
    step(3);
    m_therm = 1'b0; m_uv = 1'b1; m_flt = fault_flag; m_low = 0;
    chk("R5", "random start clear", fault_flag, 1'b0);
    begin
      int hold_left;
      logic cause;
      logic nxt_out;
      hold_left = 0;
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        chk("R13", "rnd fault_flag", fault_flag, m_flt);
        chk("R4", "rnd out_en", out_en, f_out(hold_n, m_uv, m_flt));
        chk("R10", "rnd bias_en", bias_en, f_bias(hold_n, bias_force, m_uv, m_flt));
        chk("R12", "rnd lp_en", lp_en, f_out(hold_n, m_uv, m_flt) & lowpwr_req);
        if (hold_left > 0) begin
          hold_left--;
          hold_n = (hold_left == 0);
        end else if ($urandom_range(99) < 3) begin
          hold_left = $urandom_range(PULSE_CYC + 6, PULSE_CYC - 6);
          hold_n = 1'b0;
        end
        temp_code  = ($urandom_range(99) < 4) ? 8'($urandom_range(200, 161))
                                              : 8'($urandom_range(150, 100));
        vsup_code  = 8'($urandom_range(95, 74));
        lowpwr_req = 1'($urandom_range(1));
        bias_force = ($urandom_range(9) == 0);
        ovc_drv    = ($urandom_range(99) == 0);
        nxt_out = f_out(hold_n, m_uv, m_flt);
        cause   = m_therm | (ovc_drv & nxt_out);
        if (cause) m_flt = 1'b1;
        else if (m_flt && hold_n && m_low >= PULSE_CYC) m_flt = 1'b0;
        m_low   = hold_n ? 0 : m_low + 1;
        m_therm = f_hyst(m_therm, int'(temp_code), TEMP_TRIP, TEMP_REARM);
        m_uv    = f_hyst(m_uv, int'(vsup_code), VSUP_ON, VSUP_OFF);
      end
    end
    ovc_drv = 1'b0; hold_n = 1'b1;
    step(2);
    finish_run();
  end

endmodule